// File: doc/BRIEF.md
# Mode-Controlled Rotate/Shift Unit

This block takes a data word of configurable width (eight bits unless set otherwise) and, under a two-bit mode input, produces one of four one-position transforms of it: the word unchanged, the word rotated one place toward the least significant end, the word rotated one place toward the most significant end, or the word shifted one place toward the least significant end with the sign bit copied in. The chosen result is loaded into an output register on each rising clock edge.

All four transforms are formed in parallel from the current input word, and a decoded one-hot selector picks one of them. When the mode input carries unknown or floating bits, the selector decodes to no valid operation, and the whole next output is driven to unknown. A wrong mode therefore shows up at once in a four-state simulation and is not hidden behind a plausible-looking value.

Top module: `rsu_top`

## Requirements
- R1: Mode 2'b00 passes the input through, so after the next rising edge `dout` equals the `din` sampled at that edge.
- R2: Mode 2'b01 rotates right by one. After the edge, `dout[i]` equals `din[i+1]` for i below W-1, and `dout[W-1]` equals `din[0]`.
- R3: Mode 2'b10 rotates left by one. After the edge, `dout[i]` equals `din[i-1]` for i above 0, and `dout[0]` equals `din[W-1]`.
- R4: Mode 2'b11 shifts right arithmetically by one. After the edge, `dout[W-1]` equals `din[W-1]`, and `dout[i]` equals `din[i+1]` for i below W-1. This holds for negative and positive inputs.
- R5: A mode value with any unknown or high-impedance bit drives every bit of the next registered output to unknown. Any of the four defined codes gives a fully known output.
- R6: The behaviour of R1 to R4 holds for any width W of at least 2. W defaults to 8.
- R7: A high `rst` sampled at a rising edge clears `dout` to all zeros on that edge. It takes priority over any mode and data presented in the same cycle.
- R8: `dout` changes only at rising clock edges. Changes on `din` or `ctrl` between edges leave it unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear |
| ctrl | input | 2 | Operation select (00 pass, 01 rotate right, 10 rotate left, 11 arithmetic right shift) |
| din | input | W | Data word to transform |
| dout | output | W | Registered result |

## Verification
Clearing and a transform can land on the same edge. The bench provokes this by raising `rst` while it presents a rotate mode together with a nonzero word whose transform is also nonzero, and it expects all zeros. A mode change and a data change can also arrive inside one period. The bench changes both between edges and confirms that `dout` keeps its old value until the next edge and then takes the transform of the newest pair.

// File: rtl/rsu_pkg.sv
package rsu_pkg;

  typedef enum logic [1:0] {
    OP_PASS = 2'b00,
    OP_ROR  = 2'b01,
    OP_ROL  = 2'b10,
    OP_ASR  = 2'b11
  } op_e;

  localparam int NOPS = 4;

endpackage

// File: rtl/rsu_decode.sv
module rsu_decode
  import rsu_pkg::*;
(
  input  logic [1:0]      ctrl,
  output logic [NOPS-1:0] sel,
  output logic            ctrl_ok
);

  always_comb begin
    sel     = '0;
    ctrl_ok = 1'b1;
    case (ctrl)
      OP_PASS: sel[OP_PASS] = 1'b1;
      OP_ROR:  sel[OP_ROR]  = 1'b1;
      OP_ROL:  sel[OP_ROL]  = 1'b1;
      OP_ASR:  sel[OP_ASR]  = 1'b1;
      default: ctrl_ok = 1'b0;
    endcase
  end

  // R5: a valid decode fires exactly one operation, an invalid one fires none
  always_comb begin
    if (ctrl_ok) begin
      assert_sel_single_R5: assert ($countones(sel) == 1);
    end else begin
      assert_sel_none_R5: assert (sel == '0);
    end
  end

endmodule

// File: rtl/rsu_datapath.sv
module rsu_datapath
  import rsu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]           din,
  output logic [NOPS-1:0][W-1:0] cand
);

  function automatic logic [W-1:0] f_ror(input logic [W-1:0] d);
    return {d[0], d[W-1:1]};
  endfunction

  function automatic logic [W-1:0] f_rol(input logic [W-1:0] d);
    return {d[W-2:0], d[W-1]};
  endfunction

  function automatic logic [W-1:0] f_asr(input logic [W-1:0] d);
    return {d[W-1], d[W-1:1]};
  endfunction

  function automatic logic [W-1:0] op_result(input op_e op, input logic [W-1:0] d);
    case (op)
      OP_ROR:  return f_ror(d);
      OP_ROL:  return f_rol(d);
      OP_ASR:  return f_asr(d);
      default: return d;
    endcase
  endfunction

  for (genvar k = 0; k < NOPS; k++) begin : g_op
    always_comb cand[k] = op_result(op_e'(k), din);
  end

endmodule

// File: rtl/rsu_select.sv
module rsu_select
  import rsu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [NOPS-1:0]        sel,
  input  logic                   ctrl_ok,
  input  logic [NOPS-1:0][W-1:0] cand,
  output logic [W-1:0]           nxt
);

  always_comb begin
    nxt = '0;
    for (int k = 0; k < NOPS; k++) begin
      if (sel[k]) nxt = nxt | cand[k];
    end
    if (!ctrl_ok) nxt = 'x;
  end

endmodule

// File: rtl/rsu_top.sv
module rsu_top
  import rsu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   ctrl,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  localparam int MSB = W - 1;

  logic [NOPS-1:0]        op_fire;
  logic                   ctrl_ok;
  logic [NOPS-1:0][W-1:0] cand;
  logic [W-1:0]           nxt;

  rsu_decode u_dec (
    .ctrl    (ctrl),
    .sel     (op_fire),
    .ctrl_ok (ctrl_ok)
  );

  rsu_datapath #(.W(W)) u_dp (
    .din  (din),
    .cand (cand)
  );

  rsu_select #(.W(W)) u_sel (
    .sel     (op_fire),
    .ctrl_ok (ctrl_ok),
    .cand    (cand),
    .nxt     (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) dout <= '0;
    else     dout <= nxt;
  end

  assert_clear_R7: assert property (@(posedge clk) rst |=> dout == '0);

  assert_pass_R1: assert property (@(posedge clk) disable iff (rst)
    (ctrl == 2'b00) |=> dout == $past(din));

  assert_ror_R2: assert property (@(posedge clk) disable iff (rst)
    (ctrl == 2'b01) |=> (dout[MSB] == $past(din[0])) && (dout[MSB-1:0] == $past(din[MSB:1])));

  assert_rol_R3: assert property (@(posedge clk) disable iff (rst)
    (ctrl == 2'b10) |=> (dout[0] == $past(din[MSB])) && (dout[MSB:1] == $past(din[MSB-1:0])));

  assert_asr_R4: assert property (@(posedge clk) disable iff (rst)
    (ctrl == 2'b11) |=> (dout[MSB] == $past(din[MSB])) && (dout[MSB-1:0] == $past(din[MSB:1])));

  assert_edge_only_R8: assert property (@(posedge clk) disable iff (rst)
    $stable(ctrl) && $stable(din) && $past(!rst) |=> $stable(dout));

endmodule

// File: tb/sim_rsu_top.sv
module sim_rsu_top;

  localparam int W0 = 8;
  localparam int W1 = 13;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    ctrl = 2'b00;
  logic [W0-1:0] din0 = '0;
  logic [W1-1:0] din1 = '0;
  logic [W0-1:0] dout0;
  logic [W1-1:0] dout1;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  rsu_top #(.W(W0)) u0 (.clk(clk), .rst(rst), .ctrl(ctrl), .din(din0), .dout(dout0));
  rsu_top #(.W(W1)) u1 (.clk(clk), .rst(rst), .ctrl(ctrl), .din(din1), .dout(dout1));

  // independent reference, built bit by bit from the requirement wording
  function automatic logic [63:0] ref_op(input logic [1:0] op, input logic [63:0] d, input int w);
    logic [63:0] r = '0;
    for (int i = 0; i < w; i++) begin
      case (op)
        2'b00: r[i] = d[i];
        2'b01: r[i] = d[(i + 1) % w];
        2'b10: r[i] = d[(i + w - 1) % w];
        default: r[i] = (i == w - 1) ? d[w-1] : d[i+1];
      endcase
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic [1:0] op, input logic [W0-1:0] a, input logic [W1-1:0] b);
    @(negedge clk);
    ctrl = op; din0 = a; din1 = b;
    @(posedge clk); #1;
    chk(req, 64'(dout0), ref_op(op, 64'(a), W0));
    chk({req, " w13"}, 64'(dout1), ref_op(op, 64'(b), W1));
  endtask

  task automatic t_reset;
    @(negedge clk); rst = 1'b1; ctrl = 2'b01; din0 = 8'hA5; din1 = 13'h1ABC;
    @(posedge clk); #1;
    chk("R7 reset state", 64'(dout0), 64'h0);
    chk("R7 reset state w13", 64'(dout1), 64'h0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_pass;
    apply("R1 pass", 2'b00, 8'h3C, 13'h0F0F);
    apply("R1 pass", 2'b00, 8'hFF, 13'h1FFF);
  endtask

  task automatic t_ror;
    apply("R2 ror lsb to msb", 2'b01, 8'h01, 13'h0001);
    apply("R2 ror", 2'b01, 8'hB4, 13'h1234);
  endtask

  task automatic t_rol;
    apply("R3 rol msb to lsb", 2'b10, 8'h80, 13'h1000);
    apply("R3 rol", 2'b10, 8'h5A, 13'h0ACE);
  endtask

  task automatic t_asr;
    apply("R4 asr negative", 2'b11, 8'h81, 13'h1001);
    apply("R4 asr positive", 2'b11, 8'h7E, 13'h0FFE);
    apply("R6 asr all ones", 2'b11, 8'hFF, 13'h1FFF);
  endtask

  task automatic t_collide;
    @(negedge clk); ctrl = 2'b00; din0 = 8'h77; din1 = 13'h0777;
    @(negedge clk); rst = 1'b1; ctrl = 2'b10; din0 = 8'hC3; din1 = 13'h1C03;
    @(posedge clk); #1;
    chk("R7 reset beats rol", 64'(dout0), 64'h0);
    chk("R7 reset beats rol w13", 64'(dout1), 64'h0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_hold;
    apply("R8 setup", 2'b00, 8'h12, 13'h0345);
    @(negedge clk); ctrl = 2'b01; din0 = 8'h9D; din1 = 13'h1357;
    #2; ctrl = 2'b10; din0 = 8'h4B;
    #1;
    chk("R8 hold between edges", 64'(dout0), 64'h12);
    @(posedge clk); #1;
    chk("R8 newest pair taken", 64'(dout0), ref_op(2'b10, 64'h4B, W0));
    chk("R8 newest pair taken w13", 64'(dout1), ref_op(2'b10, 64'h1357, W1));
  endtask

  task automatic t_invalid;
    logic [1:0] seen;
    @(negedge clk); ctrl = 2'bx1; din0 = 8'h5A; din1 = 13'h0123;
    @(posedge clk); #1;
    seen = ctrl;
    if ($isunknown(seen)) begin
      n_run++;
      for (int i = 0; i < W0; i++) begin
        if (dout0[i] !== 1'bx) begin
          n_fail++;
          $display("FAIL R5: bit %0d actual %b expected x", i, dout0[i]);
          break;
        end
      end
    end else begin
      chk("R5 two-state fallback", 64'(dout0), ref_op(seen, 64'h5A, W0));
    end
    @(negedge clk); ctrl = 2'b11;
    @(posedge clk); #1;
    n_run++;
    if ($isunknown(dout0)) begin
      n_fail++;
      $display("FAIL R5: defined code actual %b expected known", dout0);
    end
  endtask

  initial begin
    t_reset();
    t_pass();
    t_ror();
    t_rol();
    t_asr();
    t_collide();
    t_hold();
    t_invalid();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule